// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block carries out indivisible read-modify-write operations on a simple request/acknowledge memory bus. A requester presents an operation code, an address, a comparand and a source operand. The sequencer reads the addressed word, computes the new value, writes it back, and returns the value it found in memory. For compare-exchange it also returns a zero flag that shows whether the comparison matched. Three operations are supported: exchange, compare-exchange and add.

A locked operation is a full barrier. The sequencer first asks the store buffer to drain and waits until the buffer reports empty. Only then does it raise the bus lock. The lock stays high over the read, the compute cycle and the write, so no other master can reach memory between the two accesses. The write cycle is issued even when a compare-exchange fails; in that case the value just read goes back unchanged. Exchange is always locked. Compare-exchange and add run without drain or lock when the request does not ask for a lock. A locked request for a plain load or store is refused with an illegal-operation pulse.

Top module: `atomic_rmw_seq`

## Requirements
- R1: Operation codes on `req_op` are 0 load, 1 store, 2 exchange, 3 compare-exchange, 4 add; codes 5 to 7 are reserved. `req_ready` is high only while the sequencer is idle. A `req_valid` pulse while `req_ready` is low is ignored: no memory change and no extra `done`. Out of reset, `req_ready` is 1 and `bus_lock`, `bus_rd`, `bus_wr`, `sb_drain`, `done` and `illegal` are 0.
- R2: For a locked operation, `sb_drain` is raised first, and `bus_lock` rises only in the cycle after `sb_empty` was seen high during the drain.
- R3: In a locked operation, `bus_lock` is high from the first read cycle through the cycle in which the write is acknowledged, and it drops in the next cycle.
- R4: Every read is acknowledged and then followed by a write cycle, which begins exactly two cycles after the read acknowledge; `bus_rd` and `bus_wr` are never high together.
- R5: A compare-exchange whose comparand equals the memory word writes `req_src`, returns the old word on `res_old` and sets `res_zf` to 1.
- R6: A compare-exchange whose comparand differs still performs the write cycle, writes the old word back unchanged, returns it on `res_old` and sets `res_zf` to 0.
- R7: An exchange writes `req_src`, returns the old word with `res_zf` 0, and is locked (with drain) even when `req_lock` is 0.
- R8: An add writes the old word plus `req_src` modulo 2^DW, and returns the old word with `res_zf` 0.
- R9: A request for load or store with `req_lock` 1, or any reserved code, gives a one-cycle `illegal` pulse in the cycle after it is accepted, with no drain, no lock and no bus cycle.
- R10: Compare-exchange and add with `req_lock` 0 perform the read and the write with `bus_lock` low and without raising `sb_drain`.
- R11: `done` is a single-cycle pulse in the cycle right after the write acknowledge, and `res_old` and `res_zf` are valid while it is high.
- R12: A load or store with `req_lock` 0 is ignored: no bus activity, no drain, no `illegal`, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_op | input | 3 | Operation code |
| req_lock | input | 1 | Request asks for a locked operation |
| req_addr | input | AW | Word address |
| req_cmp | input | DW | Comparand for compare-exchange |
| req_src | input | DW | Source operand |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| sb_empty | input | 1 | Store buffer holds no pending stores |
| sb_drain | output | 1 | Request to the store buffer to drain |
| bus_lock | output | 1 | Bus lock held |
| bus_rd | output | 1 | Read cycle request |
| bus_wr | output | 1 | Write cycle request |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Acknowledge of the current bus cycle |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Illegal-operation pulse |
| res_old | output | DW | Memory word found before the write |
| res_zf | output | 1 | Compare-exchange matched |

## Verification
The bound properties check the bus sequencing on every cycle: the lock never drops between read and write, a read acknowledge is always followed two cycles later by a write, the lock only rises after a drain that saw an empty buffer, `done` follows each write acknowledge for one cycle, and an illegal pulse comes with a silent bus. The data outcome is left to the bench's scenarios: the written value and returned flag for matching and failing compare-exchange, exchange and wrapping add, checked against a memory model. The bench also shows that exchange takes the lock without being asked, that unlocked requests skip the drain, and that requests sent while busy are dropped.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

   localparam int unsigned OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_LOAD    = 3'd0;
   localparam logic [OPC_W-1:0] OPC_STORE   = 3'd1;
   localparam logic [OPC_W-1:0] OPC_XCHG    = 3'd2;
   localparam logic [OPC_W-1:0] OPC_CMPXCHG = 3'd3;
   localparam logic [OPC_W-1:0] OPC_ADD     = 3'd4;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_DRAIN,
      SQ_RD,
      SQ_CALC,
      SQ_WR,
      SQ_FREE
   } seq_state_e;

   typedef enum logic [1:0] {
      RC_IGNORE,
      RC_RMW,
      RC_ILLEGAL
   } req_class_e;

endpackage

// File: rtl/rmw_req_decode.sv
module rmw_req_decode
   import atomic_rmw_pkg::*;
#(
   parameter bit XCHG_FORCE_LOCK = 1'b1
) (
   input  logic [OPC_W-1:0] op,
   input  logic             lock_req,
   output req_class_e       cls,
   output logic             eff_lock
);

   logic is_move;
   logic is_rmw;

   assign is_move = (op == OPC_LOAD) || (op == OPC_STORE);
   assign is_rmw  = (op == OPC_XCHG) || (op == OPC_CMPXCHG) || (op == OPC_ADD);

   always_comb begin
      if (is_rmw)
         cls = RC_RMW;
      else if (is_move && !lock_req)
         cls = RC_IGNORE;
      else
         cls = RC_ILLEGAL;
   end

   generate
      if (XCHG_FORCE_LOCK) begin : g_xchg_implicit
         assign eff_lock = lock_req || (op == OPC_XCHG);
      end else begin : g_xchg_explicit
         assign eff_lock = lock_req;
      end
   endgenerate

endmodule

// File: rtl/rmw_compute.sv
module rmw_compute
   import atomic_rmw_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic [OPC_W-1:0] op,
   input  logic [DW-1:0]    old_val,
   input  logic [DW-1:0]    cmp_val,
   input  logic [DW-1:0]    src_val,
   output logic [DW-1:0]    new_val,
   output logic             match
);

   logic [DW-1:0] sum;

   assign sum   = old_val + src_val;
   assign match = (old_val == cmp_val);

   always_comb begin
      unique case (op)
         OPC_XCHG:    new_val = src_val;
         OPC_CMPXCHG: new_val = match ? src_val : old_val;
         OPC_ADD:     new_val = sum;
         default:     new_val = old_val;
      endcase
   end

endmodule

// File: rtl/rmw_seq_fsm.sv
module rmw_seq_fsm
   import atomic_rmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_lock,
   input  logic sb_empty,
   input  logic bus_ack,
   output logic idle,
   output logic sb_drain,
   output logic bus_lock,
   output logic bus_rd,
   output logic bus_wr,
   output logic rd_take,
   output logic calc,
   output logic done
);

   seq_state_e state_q, state_d;
   logic       locked_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:  if (start) state_d = start_lock ? SQ_DRAIN : SQ_RD;
         SQ_DRAIN: if (sb_empty) state_d = SQ_RD;
         SQ_RD:    if (bus_ack) state_d = SQ_CALC;
         SQ_CALC:  state_d = SQ_WR;
         SQ_WR:    if (bus_ack) state_d = SQ_FREE;
         SQ_FREE:  state_d = SQ_IDLE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         locked_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE && start)
            locked_q <= start_lock;
      end
   end

   assign idle     = (state_q == SQ_IDLE);
   assign sb_drain = (state_q == SQ_DRAIN);
   assign bus_rd   = (state_q == SQ_RD);
   assign bus_wr   = (state_q == SQ_WR);
   assign calc     = (state_q == SQ_CALC);
   assign done     = (state_q == SQ_FREE);
   assign rd_take  = bus_rd && bus_ack;
   assign bus_lock = locked_q &&
                     ((state_q == SQ_RD) || (state_q == SQ_CALC) || (state_q == SQ_WR));

endmodule

// File: rtl/atomic_rmw_seq.sv
module atomic_rmw_seq
   import atomic_rmw_pkg::*;
#(
   parameter int unsigned AW              = 16,
   parameter int unsigned DW              = 32,
   parameter bit          XCHG_FORCE_LOCK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic          req_lock,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_cmp,
   input  logic [DW-1:0] req_src,
   output logic          req_ready,
   input  logic          sb_empty,
   output logic          sb_drain,
   output logic          bus_lock,
   output logic          bus_rd,
   output logic          bus_wr,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ack,
   output logic          done,
   output logic          illegal,
   output logic [DW-1:0] res_old,
   output logic          res_zf
);

   localparam int unsigned DBYTES = DW / 8;

   generate
      if (!(DW == 8 || DW == 16 || DW == 32 || DW == 64)) begin : g_bad_dw
         $error("atomic_rmw_seq: DW must be 8, 16, 32 or 64");
      end
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("atomic_rmw_seq: AW must lie in 1..64");
      end
      if (DBYTES * 8 != DW) begin : g_bad_bytes
         $error("atomic_rmw_seq: DW must be whole bytes");
      end
   endgenerate

   req_class_e       cls;
   logic             eff_lock;
   logic             start;
   logic             idle;
   logic             rd_take;
   logic             calc;
   logic [DW-1:0]    alu_new;
   logic             alu_match;

   logic [OPC_W-1:0] op_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    cmp_q;
   logic [DW-1:0]    src_q;
   logic [DW-1:0]    old_q;
   logic [DW-1:0]    wdata_q;
   logic [DW-1:0]    res_old_q;
   logic             res_zf_q;
   logic             illegal_q;

   rmw_req_decode #(
      .XCHG_FORCE_LOCK(XCHG_FORCE_LOCK)
   ) u_dec (
      .op       (req_op),
      .lock_req (req_lock),
      .cls      (cls),
      .eff_lock (eff_lock)
   );

   assign start = req_valid && idle && (cls == RC_RMW);

   rmw_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_lock (eff_lock),
      .sb_empty   (sb_empty),
      .bus_ack    (bus_ack),
      .idle       (idle),
      .sb_drain   (sb_drain),
      .bus_lock   (bus_lock),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .rd_take    (rd_take),
      .calc       (calc),
      .done       (done)
   );

   rmw_compute #(
      .DW(DW)
   ) u_alu (
      .op      (op_q),
      .old_val (old_q),
      .cmp_val (cmp_q),
      .src_val (src_q),
      .new_val (alu_new),
      .match   (alu_match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OPC_LOAD;
         addr_q    <= '0;
         cmp_q     <= '0;
         src_q     <= '0;
         old_q     <= '0;
         wdata_q   <= '0;
         res_old_q <= '0;
         res_zf_q  <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= req_valid && idle && (cls == RC_ILLEGAL);
         if (start) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            cmp_q  <= req_cmp;
            src_q  <= req_src;
         end
         if (rd_take)
            old_q <= bus_rdata;
         if (calc) begin
            wdata_q   <= alu_new;
            res_old_q <= old_q;
            res_zf_q  <= alu_match && (op_q == OPC_CMPXCHG);
         end
      end
   end

   assign req_ready = idle;
   assign bus_addr  = addr_q;
   assign bus_wdata = wdata_q;
   assign res_old   = res_old_q;
   assign res_zf    = res_zf_q;
   assign illegal   = illegal_q;

endmodule

// File: rtl/rmw_seq_checker.sv
module rmw_seq_checker (
   input logic clk,
   input logic rst_n,
   input logic sb_drain,
   input logic sb_empty,
   input logic bus_lock,
   input logic bus_rd,
   input logic bus_wr,
   input logic bus_ack,
   input logic done,
   input logic illegal
);

   // R2
   lock_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_lock) |-> ($past(sb_drain) && $past(sb_empty)));

   // R3
   lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_lock && !(bus_wr && bus_ack)) |=> bus_lock);

   // R3
   lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ack) |=> !bus_lock);

   // R4
   read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_ack) |-> ##2 bus_wr);

   // R4
   rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R11
   done_after_wack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ack) |=> done);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!bus_rd && !bus_wr && !bus_lock && !sb_drain));

endmodule

bind atomic_rmw_seq rmw_seq_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sb_drain (sb_drain),
   .sb_empty (sb_empty),
   .bus_lock (bus_lock),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_ack  (bus_ack),
   .done     (done),
   .illegal  (illegal)
);

// File: tb/sim_atomic_rmw_seq.sv
module sim_atomic_rmw_seq;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = 3'd0;
   logic          req_lock = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_cmp = '0;
   logic [DW-1:0] req_src = '0;
   logic          req_ready;
   logic          sb_empty;
   logic          sb_drain;
   logic          bus_lock, bus_rd, bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;
   logic          bus_ack = 1'b0;
   logic          done, illegal;
   logic [DW-1:0] res_old;
   logic          res_zf;

   always #10 clk = ~clk;

   atomic_rmw_seq #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_lock(req_lock),
      .req_addr(req_addr), .req_cmp(req_cmp), .req_src(req_src),
      .req_ready(req_ready), .sb_empty(sb_empty), .sb_drain(sb_drain),
      .bus_lock(bus_lock), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .done(done), .illegal(illegal),
      .res_old(res_old), .res_zf(res_zf)
   );

   typedef struct packed {
      logic [2:0]    op;
      logic [3:0]    a;
      logic [DW-1:0] old;
      logic          zf;
      logic [DW-1:0] newv;
      logic          locked;
   } exp_t;

   exp_t          sbq[$];
   logic [DW-1:0] mem [16];
   int            nvec = 0;
   int            nbad = 0;
   int            sb_hold = 0;
   int            lat = 0;
   int            lat_cnt = 0;
   int            cyc = 0;
   int            rd_ack_t = 0;
   int            wr_t = 0;
   bit            saw_drain = 0, saw_wr = 0, lock_bad = 0, win = 0;
   bit            prev_done = 0, prev_wrack = 0, prev_lock = 0, prev_sbe = 1, prev_wr = 0;

   assign sb_empty = (sb_hold == 0);

   task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic string op_tag(input exp_t e);
      if (e.op == 3'd2) return "R7";
      if (e.op == 3'd4) return "R8";
      return e.zf ? "R5" : "R6";
   endfunction

   // monitor, memory and store-buffer model
   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0;
      end else begin
         cyc++;
         if (sbq.size() > 0) begin
            if (sbq[0].locked) begin
               if ((bus_rd || bus_wr || (win && !done)) && !bus_lock) lock_bad = 1;
            end else if (bus_lock) lock_bad = 1;
         end
         if (bus_rd) win = 1;
         if (sb_drain) saw_drain = 1;
         if (bus_wr && !prev_wr) begin wr_t = cyc; saw_wr = 1; end
         if (bus_lock && !prev_lock)
            chk(prev_sbe, "R2 lock rose without empty buffer", {31'd0, prev_sbe}, 1);
         if (done) begin
            chk(prev_wrack, "R11 done not right after write ack", {31'd0, prev_wrack}, 1);
            chk(!prev_done, "R11 done longer than one cycle", {31'd0, prev_done}, 0);
            if (sbq.size() == 0) begin
               chk(0, "R1 done with no accepted request", {31'd0, done}, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(res_old == e.old, {op_tag(e), " res_old"}, res_old, e.old);
               chk(res_zf == e.zf, {op_tag(e), " res_zf"}, {31'd0, res_zf}, {31'd0, e.zf});
               chk(mem[e.a] == e.newv, {op_tag(e), " memory word"}, mem[e.a], e.newv);
               chk(saw_wr && (wr_t - rd_ack_t == 2), "R4 write cycle two after read ack",
                   wr_t - rd_ack_t, 2);
               chk(!lock_bad, e.locked ? "R3 lock span" : "R10 lock low when unlocked",
                   {31'd0, lock_bad}, 0);
               chk(saw_drain == e.locked, e.locked ? "R2 drain requested" : "R10 no drain",
                   {31'd0, saw_drain}, {31'd0, e.locked});
            end
            saw_drain = 0; saw_wr = 0; lock_bad = 0; win = 0;
         end
         // memory model
         if (bus_ack) begin
            bus_ack = 0;
         end else if (bus_rd || bus_wr) begin
            if (lat_cnt >= lat) begin
               bus_ack = 1;
               lat_cnt = 0;
               if (bus_wr) mem[bus_addr[3:0]] = bus_wdata;
               else begin
                  bus_rdata = mem[bus_addr[3:0]];
                  rd_ack_t = cyc;
               end
            end else lat_cnt++;
         end
         if (sb_drain && sb_hold > 0) sb_hold--;
         prev_done  = done;
         prev_wrack = bus_wr && bus_ack;
         prev_lock  = bus_lock;
         prev_wr    = bus_wr;
         prev_sbe   = sb_empty;
      end
   end

   task automatic run_op(input logic [2:0] op, input logic lk, input logic [3:0] a,
                         input logic [DW-1:0] cmp, input logic [DW-1:0] src,
                         input int hold, input int l);
      exp_t e;
      while (!req_ready || sbq.size() != 0) @(negedge clk);
      e.op = op; e.a = a; e.old = mem[a]; e.zf = 0;
      e.locked = lk || (op == 3'd2);
      case (op)
         3'd2: e.newv = src;
         3'd3: begin e.zf = (mem[a] == cmp); e.newv = e.zf ? src : mem[a]; end
         default: e.newv = mem[a] + src;
      endcase
      sb_hold = hold; lat = l;
      sbq.push_back(e);
      req_op = op; req_lock = lk; req_addr = {12'd0, a}; req_cmp = cmp; req_src = src;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_idle();
      while (!req_ready || sbq.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_refused(input logic [2:0] op, input logic lk, input bit exp_ill,
                              input string rq);
      int quiet_bad;
      wait_idle();
      sb_hold = 0;
      req_op = op; req_lock = lk; req_addr = 16'd5; req_src = 32'h1234;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      chk(illegal == exp_ill, {rq, " illegal flag"}, {31'd0, illegal}, {31'd0, exp_ill});
      quiet_bad = 0;
      for (int i = 0; i < 4; i++) begin
         if (bus_rd || bus_wr || bus_lock || sb_drain || !req_ready) quiet_bad++;
         @(negedge clk);
         if (illegal) quiet_bad++;
      end
      chk(quiet_bad == 0, {rq, " bus silent"}, quiet_bad, 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i * 32'h11;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && !bus_lock && !bus_rd && !bus_wr && !sb_drain && !done && !illegal,
          "R1 reset state", {26'd0, req_ready, bus_lock, bus_rd, bus_wr, sb_drain, done | illegal},
          32'h20);

      run_op(3'd2, 1, 4'd1, 0, 32'hDEAD_BEEF, 0, 0);            // R7 locked exchange
      run_op(3'd2, 0, 4'd2, 0, 32'h0BAD_F00D, 2, 1);            // R7 implicit lock, R2 wait
      run_op(3'd3, 1, 4'd3, 32'h1000_0033, 32'hCAFE_0001, 3, 0); // R5 match
      run_op(3'd3, 1, 4'd4, 32'h0000_0000, 32'hCAFE_0002, 0, 2); // R6 mismatch
      mem[6] = 32'hFFFF_FFFF;
      run_op(3'd4, 1, 4'd6, 0, 32'h0000_0002, 1, 1);            // R8 wraps
      run_op(3'd4, 0, 4'd7, 0, 32'h0000_0100, 0, 0);            // R10 unlocked add
      run_op(3'd3, 0, 4'd8, 32'h1, 32'h2, 0, 3);                 // R10 + R6
      run_op(3'd3, 0, 4'd1, 32'hDEAD_BEEF, 32'h5, 0, 0);         // R10 + R5

      // R1 request while busy is dropped
      begin
         logic [DW-1:0] keep9;
         keep9 = mem[9];
         run_op(3'd4, 1, 4'd10, 0, 32'h7, 3, 1);
         req_op = 3'd4; req_lock = 1; req_addr = 16'd9; req_src = 32'h55;
         req_valid = 1;
         @(negedge clk);
         req_valid = 0;
         wait_idle();
         chk(mem[9] == keep9, "R1 busy request dropped", mem[9], keep9);
      end

      run_refused(3'd0, 1, 1, "R9 locked load");
      run_refused(3'd1, 1, 1, "R9 locked store");
      run_refused(3'd6, 0, 1, "R9 reserved code");
      run_refused(3'd0, 0, 0, "R12 plain load");
      run_refused(3'd1, 0, 0, "R12 plain store");

      for (int k = 0; k < 6; k++) begin
         run_op(3'd2 + 3'(k % 3), 1'(k % 2), 4'(11 + k % 5), mem[11 + k % 5],
                32'h100 * k + 32'h3, k % 3, (k + 1) % 3);
      end
      wait_idle();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nvec++;
      nbad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule